// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned N-bit operands over N clock cycles and returns a 2N-bit product. A one-cycle `start` pulse while the block is idle captures both operands. One multiplier bit is then retired per cycle, lowest bit first. Each cycle the running result moves one place to the right, and whenever the retired bit is one the multiplicand is first added into the upper half.

The multiplier bits are stored in the low half of the product register itself. As the result shifts right, each consumed bit drops out at the bottom and the growing partial sum moves in at the top. The only other state is a register that holds the multiplicand. When the last bit has been retired, `done` pulses for one cycle. The product then stays on `product` until the next accepted start.

Top module: `shift_add_mult`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is low loads the operands. In the next cycle `busy` is 1 and `product` equals the multiplier zero-extended to 2N bits, with the upper N bits all 0.
- R3: Each busy cycle retires bit 0 of `product`. If that bit is 0, `product` in the following cycle is its previous value shifted right by one place, with 0 entering the MSB.
- R4: If the retired bit is 1, the multiplicand is added to the upper N bits. The carry-out of that N+1-bit sum enters the MSB, and the lower bits shift right by one place.
- R5: `busy` stays 1 for exactly N cycles after an accepted start.
- R6: `done` is high for exactly one cycle, in the cycle where `busy` first returns to 0. In that cycle `product` equals multiplicand × multiplier.
- R7: After `done`, `product` holds its value until the next accepted start, whatever the operand inputs do.
- R8: A `start` sampled while `busy` is 1 is ignored. The operation in progress finishes with its original operands and its original timing.
- R9: With all-ones operands, the product is (2^N−1)² and no carry is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a multiplication; acted on only while idle |
| multiplicand | input | WIDTH | Operand added into the upper half |
| multiplier | input | WIDTH | Operand whose bits are scanned, lowest first |
| busy | output | 1 | High while bits are being retired |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Running result; the final product after `done` |

## Verification
The assertions assume that `start` and both operands are stable around the rising clock edge, and that reset is only released on a clean edge. The bench therefore changes every input on the falling edge. It holds `start` for a single cycle per request, except where it deliberately pulses `start` during a busy run to exercise the ignore rule. The operand values, including all-zeros, all-ones, single-bit and alternating patterns, are all legal. No input combination lies outside the assumptions, so the bench also drives new operands while idle and asserts reset in the middle of a run.

// File: rtl/shift_add_pkg.sv
package shift_add_pkg;

  typedef enum logic {
    CTRL_IDLE = 1'b0,
    CTRL_RUN  = 1'b1
  } ctrlState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic load;  // capture operands, clear upper half
    logic step;  // retire one multiplier bit
  } samStrobes_t;

endpackage

// File: rtl/sam_control.sv
module sam_control
  import shift_add_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output samStrobes_t strobes,
  output logic        busy,
  output logic        done
);

  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

  ctrlState_t       stateQ;
  logic [CNT_W-1:0] bitCnt;
  logic             lastStep;
  logic             doneQ;

  assign busy     = (stateQ == CTRL_RUN);
  assign lastStep = busy && (bitCnt == LAST_IDX);

  always_comb begin
    strobes.load = start && !busy;
    strobes.step = busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= CTRL_IDLE;
      bitCnt <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= lastStep;
      unique case (stateQ)
        CTRL_IDLE: begin
          if (start) begin
            stateQ <= CTRL_RUN;
            bitCnt <= '0;
          end
        end
        CTRL_RUN: begin
          if (lastStep) begin
            stateQ <= CTRL_IDLE;
          end else begin
            bitCnt <= bitCnt + CNT_W'(1);
          end
        end
        default: stateQ <= CTRL_IDLE;
      endcase
    end
  end

  assign done = doneQ;

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R5
  run_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !lastStep) |=> (busy && !done));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lastStep |=> (done && !busy));

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !lastStep) |=> (bitCnt == $past(bitCnt) + CNT_W'(1)));

endmodule

// File: rtl/sam_datapath.sv
module sam_datapath
  import shift_add_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  samStrobes_t          strobes,
  input  logic [WIDTH-1:0]     multiplicand,
  input  logic [WIDTH-1:0]     multiplier,
  output logic [2*WIDTH-1:0]   product
);

  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    prodReg;
  logic [WIDTH-1:0] mcandReg;
  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   sumUpper;
  logic [PW-1:0]    nextProd;

  always_comb begin
    addend   = prodReg[0] ? mcandReg : '0;
    sumUpper = {1'b0, prodReg[PW-1:WIDTH]} + {1'b0, addend};
    nextProd = {sumUpper, prodReg[WIDTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prodReg  <= '0;
      mcandReg <= '0;
    end else if (strobes.load) begin
      prodReg  <= {{WIDTH{1'b0}}, multiplier};
      mcandReg <= multiplicand;
    end else if (strobes.step) begin
      prodReg  <= nextProd;
    end
  end

  assign product = prodReg;

  // R2
  load_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |=> (prodReg[PW-1:WIDTH] == '0));

  // R3
  zero_bit_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.step && !prodReg[0]) |=> (prodReg == ($past(prodReg) >> 1)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.load && !strobes.step) |=> $stable(prodReg));

  // R4
  mcand_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.step |=> $stable(mcandReg));

endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
  import shift_add_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  samStrobes_t strobes;

  sam_control #(.WIDTH(WIDTH)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  sam_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!done && product == '0));

endmodule

// File: tb/shift_add_mult_tb_top.sv
`timescale 1ns/1ps
module shift_add_mult_tb_top;

  localparam int N  = 8;
  localparam int PW = 2 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [N-1:0]  mcandIn = '0;
  logic [N-1:0]  mplierIn = '0;
  logic          busy;
  logic          done;
  logic [PW-1:0] product;

  int checkCnt = 0;
  int errCnt   = 0;

  // reference state
  bit          mBusy = 1'b0;
  bit          mDone = 1'b0;
  int          mK = 0;
  longint      mA = 0;
  longint      mB = 0;
  logic [63:0] mProd = '0;

  always #10 clk = ~clk;

  shift_add_mult #(.WIDTH(N)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (mcandIn),
    .multiplier   (mplierIn),
    .busy         (busy),
    .done         (done),
    .product      (product)
  );

  // after k retired bits: partial sum of the low k multiplier bits sits
  // above the N-k bits of multiplier still waiting
  function automatic logic [63:0] partialOf(longint a, longint b, int k);
    longint lowMask = (64'd1 << k) - 1;
    longint part    = a * (b & lowMask);
    return ((part << (N - k)) | (b >> k)) & ((64'd1 << PW) - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mBusy = 0; mDone = 0; mK = 0; mProd = '0;
    end else if (mBusy) begin
      mK++;
      mProd = partialOf(mA, mB, mK);
      mDone = (mK == N);
      if (mK == N) mBusy = 0;
    end else begin
      mDone = 0;
      if (start) begin
        mBusy = 1; mK = 0; mA = longint'(mcandIn); mB = longint'(mplierIn);
        mProd = partialOf(mA, mB, 0);
      end
    end
  end

  task automatic checkEq(string tag, logic [63:0] act, logic [63:0] exp);
    checkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    checkEq("R5 busy", 64'(busy), 64'(mBusy));
    checkEq("R6 done", 64'(done), 64'(mDone));
    checkEq("R3 R4 product", 64'(product), mProd);
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
  endtask

  // issue one operation; returns in the done cycle
  task automatic runOp(logic [N-1:0] a, logic [N-1:0] b, bit poke);
    start = 1'b1; mcandIn = a; mplierIn = b;
    tick();
    start = 1'b0;
    checkEq("R2 load view", 64'(product), 64'(b));
    checkEq("R2 busy", 64'(busy), 64'd1);
    for (int i = 0; i < N; i++) begin
      if (poke && i == 2) begin
        start = 1'b1; mcandIn = ~a; mplierIn = ~b;
      end
      tick();
      start = 1'b0;
      if (i < N - 1) checkEq("R5 still busy", 64'(busy), 64'd1);
    end
    checkEq("R6 done high", 64'(done), 64'd1);
    checkEq("R6 product", 64'(product), 64'(a) * 64'(b));
    if (poke) checkEq("R8 ignored start", 64'(product), 64'(a) * 64'(b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checkCnt, errCnt);
    $finish;
  end

  initial begin
    logic [N-1:0] ra = 8'h3b;
    logic [N-1:0] rb = 8'hc4;
    tick();
    checkEq("R1 busy", 64'(busy), 64'd0);
    checkEq("R1 done", 64'(done), 64'd0);
    checkEq("R1 product", 64'(product), 64'd0);
    rst_n = 1'b1;
    tick();
    checkEq("R1 after release", 64'(product), 64'd0);

    runOp(8'd6, 8'd3, 1'b0);
    checkEq("R6 six times three", 64'(product), 64'd18);
    tick();
    checkEq("R6 done drops", 64'(done), 64'd0);

    runOp(8'hff, 8'hff, 1'b0);
    checkEq("R9 all ones", 64'(product), 64'hfe01);
    // R7: hold with changing operands
    for (int i = 0; i < 5; i++) begin
      mcandIn = 8'(i * 37); mplierIn = 8'(i * 11 + 1);
      tick();
      checkEq("R7 hold", 64'(product), 64'hfe01);
    end

    runOp(8'h00, 8'hb7, 1'b0); tick();
    runOp(8'hb7, 8'h00, 1'b0); tick();
    runOp(8'h80, 8'h80, 1'b0); tick();
    runOp(8'h01, 8'hd2, 1'b0); tick();
    runOp(8'ha5, 8'h5a, 1'b1);
    tick();
    checkEq("R8 stays idle", 64'(busy), 64'd0);

    // back-to-back: start in the done cycle
    runOp(8'h13, 8'h27, 1'b0);
    runOp(8'hfe, 8'h81, 1'b0);
    tick();

    for (int j = 0; j < 20; j++) begin
      ra = ra * 8'd29 + 8'd7;
      rb = (rb << 1) ^ ((rb[7]) ? 8'h1d : 8'h00);
      runOp(ra, rb, j[0]);
      tick();
    end

    // reset during a run
    start = 1'b1; mcandIn = 8'h77; mplierIn = 8'h99;
    tick();
    start = 1'b0;
    tick(); tick();
    rst_n = 1'b0;
    tick();
    checkEq("R1 mid-run reset busy", 64'(busy), 64'd0);
    checkEq("R1 mid-run reset product", 64'(product), 64'd0);
    rst_n = 1'b1;
    tick();
    runOp(8'h0f, 8'hf0, 1'b0);
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checkCnt, errCnt);
    $finish;
  end

endmodule